// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is a register-programmed SPI master. It runs one full-duplex burst of up to 64 bytes. Software fills a 16-word data buffer, writes the burst length in bits minus one, and sets a start bit. The engine then pulls chip select low and waits one full serial-clock period. It shifts the buffer out most-significant-bit first in SPI mode 0. When capture is enabled, every bit it samples from MISO is written over the bit it has just sent. At the end a sticky completion flag rises. Software may keep chip select low so that several bursts form one longer device transaction.

A separate clock generator supplies the serial timing as a one-cycle `sck_tick` pulse at each half period of SCLK. The sequencer has five states: `ST_IDLE`, `ST_LEAD`, `ST_SHIFT_LO`, `ST_SHIFT_HI` and `ST_TAIL`. Each transition below, except the one out of `ST_IDLE`, happens on a tick:
- `ST_IDLE -> ST_LEAD` on an accepted start. CS goes low and the first bit is loaded.
- `ST_LEAD -> ST_SHIFT_LO` on the second tick.
- `ST_SHIFT_LO -> ST_SHIFT_HI`: SCLK rises and MISO is sampled.
- `ST_SHIFT_HI -> ST_SHIFT_LO`: SCLK falls and MOSI advances.
- `ST_SHIFT_HI -> ST_TAIL` after the last bit.
- `ST_TAIL -> ST_IDLE`: the done flag is set and CS is released unless the hold bit is set.

A software reset sends any state to `ST_IDLE`.

A set bit 17 in the mode register at 0x08 blocks any start. Its reset value is 1, because it marks the controller as owned by a memory-mapped read path that lies outside this block.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, cs_n is 1, SCLK and MOSI are 0, the status register (0x30) reads 0 and the mode register (0x08) reads 0x0002_0000.
- R2: A write with bit 18 set to 0x00 starts a burst if the engine is idle and 0x08 bit 17 is clear. Bit 18 of 0x00 reads 1 while a burst runs and 0 when idle.
- R3: A burst produces exactly L+1 rising SCLK edges, where L is 0x20 bits [25:17].
- R4: Bit b of a burst is bit 7-(b mod 8) of buffer byte b/8. Byte j lives in word 0x40+4*(j/4), bits [8*(j mod 4)+7 : 8*(j mod 4)]. SCLK idles low, MOSI changes only on falling edges, and SCLK changes only on a tick.
- R5: With 0x1C bit 0 set, the MISO level at each rising edge replaces the buffer bit just sent. With it clear, the buffer is unchanged. Bits past the burst length are never touched.
- R6: Status bit 4 at 0x30 goes to 1 at the end of a burst. It stays 1 until a write to 0x30 with bit 4 equal to 0. A write with bit 4 equal to 1 leaves it set.
- R7: cs_n is active low. It falls at least two ticks (one SCLK period) before the first rising edge when it was high. At the end of a burst it returns high if 0x2C bit 30 is clear and stays low if that bit is set.
- R8: A start write during a burst has no effect on the running burst.
- R9: A start write while 0x08 bit 17 is set has no effect.
- R10: Writing 1 to 0x30 bit 31 returns the engine to idle at once: cs_n high, SCLK low, busy clear, and no done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address of the register or buffer word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sck_tick | input | 1 | Half-period pulse from the serial clock generator |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Suppose the bit counter or the byte-lane mapping inside the block is wrong. The serial stream and the buffer readback then differ from the computed image within the first byte of the burst, and on every burst length in the sweep. An error in the sequencer appears at the pins within one tick. Examples are a missing lead period, a start that reloads, or a stuck `ST_TAIL`. It shows up as a wrong count of rising edges, as SCLK moving while CS is high, or as a done flag that never rises. A sticky flag, hold or soft-reset error appears on the first register read after the event.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_TAIL
    } burst_state_e;

    // register byte offsets (below the buffer window)
    localparam int OFS_CMD  = 'h00;
    localparam int OFS_MODE = 'h08;
    localparam int OFS_CAP  = 'h1C;
    localparam int OFS_LEN  = 'h20;
    localparam int OFS_CS   = 'h2C;
    localparam int OFS_STAT = 'h30;

    // field positions
    localparam int START_BIT = 18;
    localparam int MM_BIT    = 17;
    localparam int CAP_BIT   = 0;
    localparam int LEN_LSB   = 17;
    localparam int HOLD_BIT  = 30;
    localparam int DONE_BIT  = 4;
    localparam int SRST_BIT  = 31;

endpackage

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
    import spi_burst_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BIT_W  = 9,
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done_set,
    input  logic [31:0]       buf_rdata,
    output logic              go,
    output logic              srst,
    output logic              cap_en,
    output logic              hold_cs,
    output logic [BIT_W-1:0]  len_last,
    output logic              buf_we,
    output logic [WIDX_W-1:0] buf_idx,
    output logic [31:0]       buf_wdata
);

    logic             mm_en_q, cap_q, hold_q, done_q;
    logic [BIT_W-1:0] len_q;
    logic             in_buf, buf_ok;
    logic             wr_cmd, wr_mode, wr_cap, wr_len, wr_cs, wr_stat;

    assign in_buf  = bus_addr[ADDR_W-1];
    assign buf_ok  = in_buf && (bus_addr[1:0] == 2'b00);
    assign buf_idx = WIDX_W'(bus_addr[ADDR_W-2:2]);
    assign buf_we  = bus_we && buf_ok;
    assign buf_wdata = bus_wdata;

    assign wr_cmd  = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_mode = bus_we && (bus_addr == ADDR_W'(OFS_MODE));
    assign wr_cap  = bus_we && (bus_addr == ADDR_W'(OFS_CAP));
    assign wr_len  = bus_we && (bus_addr == ADDR_W'(OFS_LEN));
    assign wr_cs   = bus_we && (bus_addr == ADDR_W'(OFS_CS));
    assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFS_STAT));

    assign go   = wr_cmd && bus_wdata[START_BIT] && !busy && !mm_en_q;
    assign srst = wr_stat && bus_wdata[SRST_BIT];

    assign cap_en   = cap_q;
    assign hold_cs  = hold_q;
    assign len_last = len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mm_en_q <= 1'b1;
            cap_q   <= 1'b0;
            hold_q  <= 1'b0;
            len_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            if (wr_mode) mm_en_q <= bus_wdata[MM_BIT];
            if (wr_cap)  cap_q   <= bus_wdata[CAP_BIT];
            if (wr_len)  len_q   <= bus_wdata[LEN_LSB +: BIT_W];
            if (wr_cs)   hold_q  <= bus_wdata[HOLD_BIT];
            if (done_set)
                done_q <= 1'b1;
            else if (wr_stat && !bus_wdata[DONE_BIT])
                done_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CMD):  bus_rdata[START_BIT] = busy;
            ADDR_W'(OFS_MODE): bus_rdata[MM_BIT]    = mm_en_q;
            ADDR_W'(OFS_CAP):  bus_rdata[CAP_BIT]   = cap_q;
            ADDR_W'(OFS_LEN):  bus_rdata[LEN_LSB +: BIT_W] = len_q;
            ADDR_W'(OFS_CS):   bus_rdata[HOLD_BIT]  = hold_q;
            ADDR_W'(OFS_STAT): bus_rdata[DONE_BIT]  = done_q;
            default:           bus_rdata = buf_ok ? buf_rdata : '0;
        endcase
    end

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(wr_stat && !bus_wdata[DONE_BIT])) |=> done_q);

    assert_done_from_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy));

    assert_mm_blocks_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(mm_en_q));

endmodule

// File: rtl/spi_burst_buf.sv
module spi_burst_buf #(
    parameter int WORDS  = 16,
    parameter int WIDX_W = 4,
    parameter int BIT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [WIDX_W-1:0] bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cap_we,
    input  logic [BIT_W-1:0]  cap_idx,
    input  logic              cap_bit,
    input  logic [BIT_W-1:0]  fetch_idx,
    output logic              fetch_bit
);

    logic [WORDS*32-1:0] mem_flat;
    logic [BIT_W-1:0]    cap_pos, fetch_pos;

    // burst bit b -> byte b/8, bit 7-(b%8); byte j sits in lane j%4 of word j/4
    assign cap_pos   = {cap_idx[BIT_W-1:3],   ~cap_idx[2:0]};
    assign fetch_pos = {fetch_idx[BIT_W-1:3], ~fetch_idx[2:0]};

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                if (bus_we && bus_idx == WIDX_W'(w))
                    word_q <= bus_wdata;
                if (cap_we && cap_pos[BIT_W-1:5] == WIDX_W'(w))
                    word_q[cap_pos[4:0]] <= cap_bit;
            end
        end
        assign mem_flat[w*32 +: 32] = word_q;
    end

    assign bus_rdata = mem_flat[{bus_idx, 5'b00000} +: 32];
    assign fetch_bit = mem_flat[fetch_pos];

endmodule

// File: rtl/spi_burst_fsm.sv
module spi_burst_fsm
    import spi_burst_pkg::*;
#(
    parameter int BIT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             srst,
    input  logic [BIT_W-1:0] len_last,
    input  logic             hold_cs,
    input  logic             cap_en,
    input  logic             miso,
    input  logic             fetch_bit,
    output logic [BIT_W-1:0] fetch_idx,
    output logic             cap_we,
    output logic [BIT_W-1:0] cap_idx,
    output logic             cap_bit,
    output logic             busy,
    output logic             done_set,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi
);

    burst_state_e     state_q, state_d;
    logic [BIT_W-1:0] bit_q, last_q;
    logic             lead_q;
    logic             last_bit;

    assign last_bit = (bit_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go) state_d = ST_LEAD;
            ST_LEAD:     if (tick && lead_q) state_d = ST_SHIFT_LO;
            ST_SHIFT_LO: if (tick) state_d = ST_SHIFT_HI;
            ST_SHIFT_HI: if (tick) state_d = last_bit ? ST_TAIL : ST_SHIFT_LO;
            ST_TAIL:     if (tick) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (srst) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            mosi   <= 1'b0;
            bit_q  <= '0;
            last_q <= '0;
            lead_q <= 1'b0;
        end else if (srst) begin
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            bit_q  <= '0;
            lead_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    cs_n   <= 1'b0;
                    bit_q  <= '0;
                    lead_q <= 1'b0;
                    last_q <= len_last;
                    mosi   <= fetch_bit;
                end
                ST_LEAD: if (tick) lead_q <= 1'b1;
                ST_SHIFT_LO: if (tick) sclk <= 1'b1;
                ST_SHIFT_HI: if (tick) begin
                    sclk <= 1'b0;
                    if (!last_bit) begin
                        bit_q <= bit_q + 1'b1;
                        mosi  <= fetch_bit;
                    end
                end
                ST_TAIL: if (tick && !hold_cs) cs_n <= 1'b1;
                default: ;
            endcase
        end
    end

    assign fetch_idx = (state_q == ST_IDLE) ? '0 : bit_q + 1'b1;
    assign cap_we    = (state_q == ST_SHIFT_LO) && tick && cap_en && !srst;
    assign cap_idx   = bit_q;
    assign cap_bit   = miso;
    assign busy      = (state_q != ST_IDLE);
    assign done_set  = (state_q == ST_TAIL) && tick && !srst;

    assert_sclk_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> ($past(tick) || $past(srst)));

    assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_cs_low_while_clocking_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    assert_bit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_SHIFT_LO, ST_SHIFT_HI}) |-> (bit_q <= last_q));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {ST_SHIFT_LO, ST_SHIFT_HI, ST_TAIL}) && !srst) |=> (state_q != ST_LEAD));

    assert_srst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state_q == ST_IDLE && cs_n && !sclk));

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
    parameter int  BUF_BYTES = 64,
    localparam int ADDR_W    = $clog2(BUF_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sck_tick,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int WORDS  = BUF_BYTES / 4;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int BIT_W  = $clog2(BUF_BYTES * 8);

    logic              go, srst, cap_en, hold_cs, busy, done_set;
    logic [BIT_W-1:0]  len_last, fetch_idx, cap_idx;
    logic              buf_we, cap_we, cap_bit, fetch_bit;
    logic [WIDX_W-1:0] buf_idx;
    logic [31:0]       buf_wdata, buf_rdata;

    spi_burst_regs #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .WIDX_W(WIDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done_set(done_set), .buf_rdata(buf_rdata),
        .go(go), .srst(srst), .cap_en(cap_en), .hold_cs(hold_cs), .len_last(len_last),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata)
    );

    spi_burst_buf #(.WORDS(WORDS), .WIDX_W(WIDX_W), .BIT_W(BIT_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .bus_we(buf_we), .bus_idx(buf_idx), .bus_wdata(buf_wdata), .bus_rdata(buf_rdata),
        .cap_we(cap_we), .cap_idx(cap_idx), .cap_bit(cap_bit),
        .fetch_idx(fetch_idx), .fetch_bit(fetch_bit)
    );

    spi_burst_fsm #(.BIT_W(BIT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(sck_tick), .go(go), .srst(srst),
        .len_last(len_last), .hold_cs(hold_cs), .cap_en(cap_en),
        .miso(spi_miso), .fetch_bit(fetch_bit), .fetch_idx(fetch_idx),
        .cap_we(cap_we), .cap_idx(cap_idx), .cap_bit(cap_bit),
        .busy(busy), .done_set(done_set),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
    );

endmodule

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_CLKS  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck_tick;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    int  rise_cnt = 0;
    int  seed = 0;
    logic mosi_cap [512];
    realtime t_cs = 0, t_rise = 0;
    logic tdiv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) tdiv <= rst_n ? ~tdiv : 1'b0;
    assign sck_tick = tdiv;

    function automatic logic slv_bit(int b, int s);
        logic [7:0] v;
        v = 8'((b / 8) * 29 + s * 5 + 90);
        return v[7 - (b % 8)];
    endfunction

    function automatic logic [7:0] tx_byte(int k, int run);
        return 8'(k * 13 + run * 7 + 1);
    endfunction

    assign spi_miso = slv_bit(rise_cnt, seed);

    always @(posedge spi_sclk) begin
        if (rise_cnt == 0) t_rise = $realtime;
        if (rise_cnt < 512) mosi_cap[rise_cnt] = spi_mosi;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge spi_cs_n) t_cs = $realtime;

    spi_burst_engine u_spi_burst_engine (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            bus_rd(7'h30, d);
            if (d[4]) begin ok = 1; break; end
        end
    endtask

    task automatic run_burst(int nbits, bit cap, bit hold, int run, int restart_at);
        logic [31:0] d, expw;
        logic [7:0]  img [64];
        bit ok, cs_high;
        int bad_mosi, bad_buf;
        for (int k = 0; k < 64; k++) img[k] = tx_byte(k, run);
        for (int w = 0; w < 16; w++)
            bus_wr(7'(64 + 4 * w), {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]});
        bus_wr(7'h1C, 32'(cap));
        bus_wr(7'h20, 32'(nbits - 1) << 17);
        bus_wr(7'h2C, 32'(hold) << 30);
        bus_wr(7'h30, 32'h0);
        seed = run;
        rise_cnt = 0;
        cs_high = spi_cs_n;
        bus_wr(7'h00, 32'h0004_0000);
        if (restart_at > 0) begin
            repeat (restart_at) @(negedge clk);
            bus_wr(7'h00, 32'h0004_0000);
        end
        wait_done(ok);
        chk(ok, "R6", "done flag after burst", ok, 1);
        chk(rise_cnt == nbits, "R3", "rising SCLK edge count", rise_cnt, nbits);
        bad_mosi = 0;
        for (int b = 0; b < nbits; b++)
            if (mosi_cap[b] !== img[b/8][7 - (b % 8)]) bad_mosi++;
        chk(bad_mosi == 0, "R4", "MOSI bit mismatches", bad_mosi, 0);
        for (int b = 0; b < nbits; b++)
            if (cap) img[b/8][7 - (b % 8)] = slv_bit(b, run);
        bad_buf = 0;
        for (int w = 0; w < 16; w++) begin
            bus_rd(7'(64 + 4 * w), d);
            expw = {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]};
            if (d !== expw) bad_buf++;
        end
        chk(bad_buf == 0, "R5", "buffer words differing after burst", bad_buf, 0);
        chk(spi_cs_n == !hold, "R7", "cs_n after burst end", spi_cs_n, !hold);
        bus_rd(7'h00, d);
        chk(d[18] == 1'b0, "R2", "busy bit once idle", d[18], 0);
        if (cs_high)
            chk((t_rise - t_cs) >= 2 * TICK_CLKS * CLK_PERIOD, "R7",
                "lead time cs_n to first rise", longint'(t_rise - t_cs),
                2 * TICK_CLKS * CLK_PERIOD);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int r;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n at reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "sclk at reset", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R1", "mosi at reset", spi_mosi, 0);
        bus_rd(7'h30, d);
        chk(d == 32'h0, "R1", "status at reset", d, 0);
        bus_rd(7'h08, d);
        chk(d == 32'h0002_0000, "R1", "mode at reset", d, 32'h0002_0000);

        // R9 start blocked by memory-mapped mode bit
        rise_cnt = 0;
        bus_wr(7'h20, 32'd7 << 17);
        bus_wr(7'h00, 32'h0004_0000);
        bus_rd(7'h00, d);
        chk(d[18] == 1'b0, "R9", "busy after blocked start", d[18], 0);
        repeat (40) @(negedge clk);
        chk(rise_cnt == 0, "R9", "edges after blocked start", rise_cnt, 0);
        chk(spi_cs_n == 1'b1, "R9", "cs_n after blocked start", spi_cs_n, 1);
        bus_rd(7'h30, d);
        chk(d[4] == 1'b0, "R9", "done after blocked start", d[4], 0);
        bus_wr(7'h08, 32'h0);

        // R2 busy visible during a burst
        bus_wr(7'h20, 32'd15 << 17);
        bus_wr(7'h00, 32'h0004_0000);
        bus_rd(7'h00, d);
        chk(d[18] == 1'b1, "R2", "busy during burst", d[18], 1);
        wait_done(ok);

        // sweep every byte length, varying capture and hold
        for (int n = 1; n <= 64; n++)
            run_burst(8 * n, (n % 3) != 0, (n % 2) == 1, n, 0);
        // partial-byte lengths
        run_burst(12, 1'b1, 1'b0, 100, 0);
        run_burst(1, 1'b1, 1'b0, 101, 0);

        // R6 sticky flag clearing rule
        bus_wr(7'h30, 32'h0000_0010);
        bus_rd(7'h30, d);
        chk(d[4] == 1'b1, "R6", "done after writing 1", d[4], 1);
        bus_wr(7'h30, 32'h0);
        bus_rd(7'h30, d);
        chk(d[4] == 1'b0, "R6", "done after writing 0", d[4], 0);

        // R8 second start in mid-burst
        run_burst(32, 1'b1, 1'b0, 102, 30);
        chk(rise_cnt == 32, "R8", "edges with start during burst", rise_cnt, 32);

        // R10 soft reset in mid-burst
        bus_wr(7'h20, 32'd511 << 17);
        bus_wr(7'h30, 32'h0);
        rise_cnt = 0;
        bus_wr(7'h00, 32'h0004_0000);
        repeat (30) @(negedge clk);
        bus_wr(7'h30, 32'h8000_0000);
        chk(spi_cs_n == 1'b1, "R10", "cs_n after soft reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R10", "sclk after soft reset", spi_sclk, 0);
        bus_rd(7'h00, d);
        chk(d[18] == 1'b0, "R10", "busy after soft reset", d[18], 0);
        r = rise_cnt;
        repeat (60) @(negedge clk);
        chk(rise_cnt == r, "R10", "edges after soft reset", rise_cnt, r);
        bus_rd(7'h30, d);
        chk(d[4] == 1'b0, "R10", "done after soft reset", d[4], 0);
        run_burst(16, 1'b1, 1'b0, 103, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule